// File: doc/BRIEF.md
# Transmit Timeslot Cross-Connect Engine

This block builds the outgoing serial streams of an eight-port time-division cross-connect. It runs its own transmit frame clock. Each frame is one framing bit followed by 24 timeslots of 8 bits. Before each outgoing timeslot, the block decides what every port will send. For each destination port and timeslot it reads a cross-connect map. The map names one stored receive byte, given as a source port and a source timeslot. The block then fetches that byte from the receive buffer and shifts it out serially.

A single sequencer serves all eight ports, one after another. This lets them share one map read port and one buffer read port. As a result each bit position on the line lasts one clock per port. Both memories are external and read synchronously. The block only reads them. The map is loaded elsewhere, and the buffer is filled by the receive capture path.

Top module: `xc_tx_engine`

## Requirements
- R1: While `rstN` is low, every `txSer` bit, `txSync`, `txChanStart`, `mapRdEn` and `bufRdEn` are 0.
- R2: Each line bit position lasts exactly NUM_PORTS (8) clocks, and `txSer`, `txSync` and `txChanStart` change only at the start of a bit position.
- R3: A frame is 193 bit positions. `txSync` is 1 during the single framing-bit position and 0 in all other positions. The position after the framing bit is bit 0 of timeslot 0.
- R4: `txChanStart` is 1 during the first bit position of each of the 24 timeslots and 0 during the framing bit and all other bits.
- R5: During the framing-bit position every `txSer` bit is 0.
- R6: Map reads use address {port (3 bits, [7:5]), timeslot (5 bits, [4:0])}, with timeslot in 0..23. One read is made per port per timeslot, for ports 0 to 7 in consecutive clocks, so a frame makes exactly 192 map reads.
- R7: Both memories have one-cycle read latency. `bufRdEn` is 1 exactly one clock after `mapRdEn`, and `bufRdAddr` equals the map word returned for that read.
- R8: In timeslot s, port p transmits byte buffer[map[{p,s}]], MSB first, with one bit per bit position. Any number of ports and timeslots may point at the same source byte.
- R9: The 16th rising clock edge after reset release starts the first framing bit. That first frame already carries the mapped data of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mapRdEn | output | 1 | Map memory read strobe |
| mapRdAddr | output | 8 | Map address {port, timeslot} |
| mapRdData | input | 8 | Map word (source buffer address), valid one clock after the read |
| bufRdEn | output | 1 | Receive buffer read strobe |
| bufRdAddr | output | 8 | Receive buffer address |
| bufRdData | input | 8 | Buffer byte, valid one clock after the read |
| txSer | output | 8 | Serial data, one bit per port |
| txSync | output | 1 | High during the framing-bit position |
| txChanStart | output | 1 | High during the first bit of each timeslot |

## Verification
The bench sweeps five map and buffer patterns. They include identity, mirrored port and slot order, every destination broadcasting one source, scattered addresses, and alternating all-zero and all-one bytes. For each pattern it checks every port and every timeslot of a whole frame.

A prefetch placed too late would show up in timeslot 0. That slot's data is fetched across the framing bit, so the slot would carry the previous frame's or the reset value. A pipeline tag off by one would write a byte into a neighbouring port's lane, and the broadcast and mirrored patterns expose it. A bit order or shift fault would corrupt the single-bit patterns.

The bench also checks the exact clock of the first sync after reset. It checks for a framing bit that leaks data or a channel strobe. It counts map reads per frame, which catches a missed or extra port. Finally, it checks the buffer address against the map word one clock earlier.

// File: rtl/xc_tx_pkg.sv
package xc_tx_pkg;

  // Strobes from the sequencer to the datapath, valid in the last clock
  // of a bit position and describing the position about to begin.
  typedef struct packed {
    logic bitEnd;        // current bit position ends at this edge
    logic nextFraming;   // next position is the framing bit
    logic nextSlotStart; // next position is bit 0 of a timeslot
  } seqStrobe_t;

endpackage

// File: rtl/xc_tx_seq.sv
module xc_tx_seq
  import xc_tx_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_BITS = 8,
  parameter int PORT_W    = 3,
  parameter int SLOT_W    = 5,
  parameter int BIT_W     = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  output seqStrobe_t               strobe,
  output logic [PORT_W-1:0]        phase,
  output logic                     mapRdEn,
  output logic [PORT_W+SLOT_W-1:0] mapRdAddr,
  output logic                     txSync,
  output logic                     txChanStart
);

  localparam logic [PORT_W-1:0] LAST_PORT  = PORT_W'(NUM_PORTS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(SLOT_BITS - 1);
  localparam logic [BIT_W-1:0]  FETCH_BIT  = BIT_W'(SLOT_BITS - 2);

  logic              framing;
  logic [SLOT_W-1:0] slotIdx;
  logic [BIT_W-1:0]  bitIdx;
  logic              lastBit;
  logic              lastSlot;
  logic              fetchFirst;
  logic              fetchNext;
  logic [SLOT_W-1:0] fetchSlot;

  assign lastBit  = (bitIdx == LAST_BIT);
  assign lastSlot = (slotIdx == LAST_SLOT);

  // Timing strobes for the position that follows the current one.
  assign strobe.bitEnd        = (phase == LAST_PORT);
  assign strobe.nextFraming   = !framing && lastBit && lastSlot;
  assign strobe.nextSlotStart = framing || (lastBit && !lastSlot);

  // Prefetch window: the bit position two before the target slot's first bit.
  // Slot 0 is fetched in the last bit of the final slot, across the framing bit.
  assign fetchFirst = !framing && lastBit && lastSlot;
  assign fetchNext  = !framing && (bitIdx == FETCH_BIT) && !lastSlot;
  assign fetchSlot  = fetchFirst ? '0 : slotIdx + SLOT_W'(1);

  assign mapRdEn   = fetchFirst || fetchNext;
  assign mapRdAddr = {phase, fetchSlot};

  // Port phase: one clock per port inside each bit position.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (strobe.bitEnd) begin
      phase <= '0;
    end else begin
      phase <= phase + PORT_W'(1);
    end
  end

  // Frame position: framing flag, slot and bit counters.
  // Reset lands two positions before the framing bit so slot 0 is prefetched.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framing <= 1'b0;
      slotIdx <= LAST_SLOT;
      bitIdx  <= FETCH_BIT;
    end else if (strobe.bitEnd) begin
      if (framing) begin
        framing <= 1'b0;
        slotIdx <= '0;
        bitIdx  <= '0;
      end else if (lastBit) begin
        bitIdx <= '0;
        if (lastSlot) begin
          framing <= 1'b1;
        end else begin
          slotIdx <= slotIdx + SLOT_W'(1);
        end
      end else begin
        bitIdx <= bitIdx + BIT_W'(1);
      end
    end
  end

  // Registered line timing outputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSync      <= 1'b0;
      txChanStart <= 1'b0;
    end else if (strobe.bitEnd) begin
      txSync      <= strobe.nextFraming;
      txChanStart <= strobe.nextSlotStart;
    end
  end

endmodule

// File: rtl/xc_tx_lane.sv
module xc_tx_lane
  import xc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              serOut
);

  logic [DATA_W-1:0] holdByte;
  logic [DATA_W-1:0] shiftReg;

  // Holding register: the byte fetched for the upcoming timeslot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
    end else if (wrEn) begin
      holdByte <= wrData;
    end
  end

  // Output shifter, MSB first, advanced once per bit position.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.bitEnd) begin
      if (strobe.nextFraming) begin
        shiftReg <= '0;
      end else if (strobe.nextSlotStart) begin
        shiftReg <= holdByte;
      end else begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign serOut = shiftReg[DATA_W-1];

endmodule

// File: rtl/xc_tx_datapath.sv
module xc_tx_datapath
  import xc_tx_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int BUF_AW    = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 mapRdEn,
  input  logic [PORT_W-1:0]    phase,
  input  logic [BUF_AW-1:0]    mapRdData,
  output logic                 bufRdEn,
  output logic [BUF_AW-1:0]    bufRdAddr,
  input  logic [DATA_W-1:0]    bufRdData,
  output logic [NUM_PORTS-1:0] txSer
);

  logic              mapValid;
  logic [PORT_W-1:0] mapTag;
  logic              bufValid;
  logic [PORT_W-1:0] bufTag;

  // Two-stage tag pipeline following the map read and the buffer read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapValid <= 1'b0;
      mapTag   <= '0;
      bufValid <= 1'b0;
      bufTag   <= '0;
    end else begin
      mapValid <= mapRdEn;
      mapTag   <= phase;
      bufValid <= mapValid;
      bufTag   <= mapTag;
    end
  end

  // The map word is the receive buffer address.
  assign bufRdEn   = mapValid;
  assign bufRdAddr = mapRdData;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gLane
    logic laneWr;
    assign laneWr = bufValid && (bufTag == PORT_W'(g));

    xc_tx_lane #(
      .DATA_W (DATA_W)
    ) uLane (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .wrEn   (laneWr),
      .wrData (bufRdData),
      .serOut (txSer[g])
    );
  end

endmodule

// File: rtl/xc_tx_engine.sv
module xc_tx_engine
  import xc_tx_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_BITS = 8,
  parameter int BUF_AW    = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  output logic                                      mapRdEn,
  output logic [$clog2(NUM_PORTS)+$clog2(NUM_SLOTS)-1:0] mapRdAddr,
  input  logic [BUF_AW-1:0]                         mapRdData,
  output logic                                      bufRdEn,
  output logic [BUF_AW-1:0]                         bufRdAddr,
  input  logic [SLOT_BITS-1:0]                      bufRdData,
  output logic [NUM_PORTS-1:0]                      txSer,
  output logic                                      txSync,
  output logic                                      txChanStart
);

  localparam int PORT_W = $clog2(NUM_PORTS);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int ADDR_W = PORT_W + SLOT_W;

  seqStrobe_t        strobe;
  logic [PORT_W-1:0] seqPhase;

  xc_tx_seq #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .PORT_W    (PORT_W),
    .SLOT_W    (SLOT_W),
    .BIT_W     (BIT_W)
  ) uSeq (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .phase       (seqPhase),
    .mapRdEn     (mapRdEn),
    .mapRdAddr   (mapRdAddr),
    .txSync      (txSync),
    .txChanStart (txChanStart)
  );

  xc_tx_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .BUF_AW    (BUF_AW),
    .DATA_W    (SLOT_BITS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mapRdEn   (mapRdEn),
    .phase     (seqPhase),
    .mapRdData (mapRdData),
    .bufRdEn   (bufRdEn),
    .bufRdAddr (bufRdAddr),
    .bufRdData (bufRdData),
    .txSer     (txSer)
  );

endmodule

// File: rtl/xc_tx_checker.sv
module xc_tx_checker #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [PORT_W-1:0]    seqPhase,
  input logic                 mapRdEn,
  input logic [ADDR_W-1:0]    mapRdAddr,
  input logic                 bufRdEn,
  input logic [NUM_PORTS-1:0] txSer,
  input logic                 txSync,
  input logic                 txChanStart
);

  // Outputs hold for the whole bit position.
  assert_line_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqPhase != '0) |-> ($stable(txSer) && $stable(txSync) && $stable(txChanStart)));

  // The position after the framing bit opens timeslot 0.
  assert_slot0_follows_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txSync) |-> txChanStart);

  assert_no_chan_in_framing_R4: assert property (@(posedge clk) disable iff (!rstN)
    txSync |-> !txChanStart);

  assert_framing_bit_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    txSync |-> (txSer == '0));

  assert_port_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mapRdEn && $past(mapRdEn)) |->
      (mapRdAddr[ADDR_W-1 -: PORT_W] == $past(mapRdAddr[ADDR_W-1 -: PORT_W]) + PORT_W'(1)));

  assert_buf_follows_map_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn == $past(mapRdEn));

endmodule

bind xc_tx_engine xc_tx_checker #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .ADDR_W    (ADDR_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .seqPhase    (seqPhase),
  .mapRdEn     (mapRdEn),
  .mapRdAddr   (mapRdAddr),
  .bufRdEn     (bufRdEn),
  .txSer       (txSer),
  .txSync      (txSync),
  .txChanStart (txChanStart)
);

// File: tb/sim_xc_tx_engine.sv
`timescale 1ns/1ps
module sim_xc_tx_engine;

  localparam int PORTS = 8;
  localparam int SLOTS = 24;
  localparam int BITS  = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mapRdEn;
  logic [7:0] mapRdAddr;
  logic [7:0] mapRdData;
  logic       bufRdEn;
  logic [7:0] bufRdAddr;
  logic [7:0] bufRdData;
  logic [7:0] txSer;
  logic       txSync;
  logic       txChanStart;

  logic [7:0] mapMem [256];
  logic [7:0] bufMem [256];

  int vecs = 0;
  int errs = 0;
  int mapCnt = 0;
  int badAddr = 0;
  int badBuf = 0;
  logic       prevEn = 1'b0;
  logic [7:0] prevAddr = '0;

  always #5 clk = ~clk;

  xc_tx_engine u0 (
    .clk         (clk),
    .rstN        (rstN),
    .mapRdEn     (mapRdEn),
    .mapRdAddr   (mapRdAddr),
    .mapRdData   (mapRdData),
    .bufRdEn     (bufRdEn),
    .bufRdAddr   (bufRdAddr),
    .bufRdData   (bufRdData),
    .txSer       (txSer),
    .txSync      (txSync),
    .txChanStart (txChanStart)
  );

  // Synchronous-read memory models and read-port monitors (R6, R7).
  always @(posedge clk) begin
    if (mapRdEn) mapRdData <= mapMem[mapRdAddr];
    if (bufRdEn) bufRdData <= bufMem[bufRdAddr];
    if (rstN) begin
      if (mapRdEn) begin
        mapCnt++;
        if (int'(mapRdAddr[4:0]) >= SLOTS) badAddr++;
        if (prevEn && mapRdAddr[7:5] != prevAddr[7:5] + 3'd1) badAddr++;
        if (!prevEn && mapRdAddr[7:5] != 3'd0) badAddr++;
      end
      if (bufRdEn != prevEn) badBuf++;
      if (bufRdEn && bufRdAddr != mapMem[prevAddr]) badBuf++;
    end
    prevEn   <= mapRdEn;
    prevAddr <= mapRdAddr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int kind);
    for (int a = 0; a < 256; a++) begin
      int p = a >> 5;
      int s = a & 31;
      case (kind)
        0: begin mapMem[a] = 8'(a); bufMem[a] = 8'(a * 37 + 11); end
        1: begin
             mapMem[a] = (s < SLOTS) ? 8'(((7 - p) << 5) | (23 - s)) : 8'h00;
             bufMem[a] = 8'(a ^ 8'hA5);
           end
        2: begin mapMem[a] = 8'h4D; bufMem[a] = (a == 8'h4D) ? 8'h81 : 8'h00; end
        3: begin mapMem[a] = 8'(a * 29 + 7); bufMem[a] = 8'(1 << (a % 8)); end
        default: begin
             mapMem[a] = (((a & 1) ^ (p & 1)) != 0) ? 8'hFF : 8'h00;
             bufMem[a] = (a == 8'hFF) ? 8'hFF : ((a == 0) ? 8'h00 : 8'h5A);
           end
      endcase
    end
  endtask

  // Checks one full frame; entered at the first clock of a framing bit.
  task automatic frameAtSync(input int kind);
    logic [7:0] got [PORTS];
    logic [7:0] snapSer;
    logic       snapSync, snapChan;
    bit         stableOk;
    int         cnt0 = mapCnt;
    int         addrBad0 = badAddr;
    int         bufBad0 = badBuf;
    chk(txSync == 1'b1, "R3 sync at framing bit", int'(txSync), 1);
    chk(txChanStart == 1'b0, "R4 no channel strobe in framing bit", int'(txChanStart), 0);
    chk(txSer == 8'h00, "R5 framing bit data", int'(txSer), 0);
    for (int s = 0; s < SLOTS; s++) begin
      stableOk = 1'b1;
      for (int b = 0; b < BITS; b++) begin
        snapSer = txSer; snapSync = txSync; snapChan = txChanStart;
        for (int c = 1; c < PORTS; c++) begin
          @(negedge clk);
          if (txSer != snapSer || txSync != snapSync || txChanStart != snapChan)
            stableOk = 1'b0;
        end
        @(negedge clk);
        if (txSync != 1'b0) chk(1'b0, $sformatf("R3 sync inside slot %0d", s), int'(txSync), 0);
        if (txChanStart != (b == 0))
          chk(1'b0, $sformatf("R4 channel strobe slot %0d bit %0d", s, b), int'(txChanStart), int'(b == 0));
        for (int p = 0; p < PORTS; p++) got[p][7 - b] = txSer[p];
      end
      chk(stableOk, $sformatf("R2 outputs steady within bits, slot %0d", s), int'(stableOk), 1);
      for (int p = 0; p < PORTS; p++) begin
        logic [7:0] expB = bufMem[mapMem[8'((p << 5) | s)]];
        chk(got[p] == expB, $sformatf("R8 pattern %0d port %0d slot %0d", kind, p, s),
            int'(got[p]), int'(expB));
      end
    end
    // last bit of slot 23 done; framing bit must come next
    for (int c = 1; c < PORTS; c++) @(negedge clk);
    @(negedge clk);
    chk(txSync == 1'b1, "R3 frame length 193 positions", int'(txSync), 1);
    chk(mapCnt - cnt0 == PORTS * SLOTS, "R6 map reads per frame", mapCnt - cnt0, PORTS * SLOTS);
    chk(badAddr == addrBad0, "R6 map address order and range", badAddr - addrBad0, 0);
    chk(badBuf == bufBad0, "R7 buffer read strobe and address", badBuf - bufBad0, 0);
  endtask

  task automatic nextSync();
    while (txSync) @(negedge clk);
    while (!txSync) @(negedge clk);
  endtask

  initial begin
    fill(0);
    repeat (4) @(negedge clk);
    chk(txSer == 8'h00, "R1 serial data in reset", int'(txSer), 0);
    chk(txSync == 1'b0, "R1 sync in reset", int'(txSync), 0);
    chk(txChanStart == 1'b0, "R1 channel strobe in reset", int'(txChanStart), 0);
    chk(mapRdEn == 1'b0 && bufRdEn == 1'b0, "R1 read strobes in reset",
        int'({mapRdEn, bufRdEn}), 0);
    rstN = 1'b1;
    repeat (15) @(negedge clk);
    chk(txSync == 1'b0, "R9 no sync before 16th edge", int'(txSync), 0);
    @(negedge clk);
    chk(txSync == 1'b1, "R9 sync at 16th edge", int'(txSync), 1);
    frameAtSync(0);
    for (int k = 1; k < 5; k++) begin
      fill(k);
      nextSync();
      frameAtSync(k);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1_000_000;
    errs++;
    vecs++;
    $display("FAIL watchdog: actual timeout expected completion (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule